// File: doc/BRIEF.md
# External Interrupt Line Detector with Sticky Status

This block watches a small group of external interrupt pins. Each pin has its own 2-bit detection type, which software sets through a simple register bus. Each pin also has a status bit, and that bit drives the pin's interrupt output directly. Every pin first passes through a two-flop synchroniser. Detection then works on the synchronised samples, so the block is safe against asynchronous pin activity.

In low-level mode the status bit mirrors the synchronised pin, inverted: it reads 1 for as long as the pin is held low. In the three edge modes the status bit is sticky. A qualifying edge sets it, and only software can remove it. The clear is deliberately restricted. A write of 0 clears a bit only when the line is in an edge mode and the bit is already set. Every other write to the status register leaves the bit untouched. If a new edge arrives in the same cycle as a valid clear, the event is kept.

The bus has one select bit, a write strobe, write data and combinational read data. Select 0 addresses the type register. Select 1 addresses the status register.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset is released, the type register reads 0, the status register reads 0 and every interrupt output is low, provided all pins are held high.
- R2: The type register (select 0) holds line i's mode in bits [2i+1:2i]. The encodings are 00 = low level, 01 = falling edge, 10 = rising edge and 11 = both edges. A write stores the data, and a read returns the stored value.
- R3: The status register (select 1) holds line i's status in bit i, and the upper read bits are 0. Interrupt output i always equals status bit i.
- R4: In low-level mode, status bit i reads 1 while the synchronised pin is low and 0 while it is high. The bit reflects a pin change three clock edges after the change.
- R5: In falling-edge mode, a high-to-low transition of the pin sets the status bit three clock edges later, and a low-to-high transition does not set it.
- R6: In rising-edge mode, a low-to-high transition sets the status bit, and a high-to-low transition does not set it.
- R7: In both-edges mode, a transition in either direction sets the status bit.
- R8: In any edge mode, writing 0 to a status bit that reads 1 clears it at the next clock edge.
- R9: In an edge mode, writing 1 to a status bit changes nothing. Writing 0 while the bit reads 0 changes nothing. The bit stays set across idle cycles until it is cleared.
- R10: In low-level mode, writes to the status register have no effect on the bit, whichever value is written.
- R11: If an edge is detected in the same cycle that a valid clear is written, the status bit remains 1.
- R12: Writes and pin activity on one line do not change the status of any other line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pin_i | input | NLINES | External interrupt pins, asynchronous |
| bus_sel_i | input | 1 | Register select: 0 type, 1 status |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 2*NLINES | Write data |
| bus_rdata_o | output | 2*NLINES | Read data for the selected register |
| irq_o | output | NLINES | Per-line interrupt outputs |

## Verification
The bench sweeps every mode on every line with a falling and then a rising pin transition. After each step it compares the whole status vector, so a wrong edge polarity in any mode shows up, and so does an event leaking into a neighbouring line. Between transitions it writes 1s, writes 0 to a set bit and writes 0 to a clear bit. This catches a design that clears on a written 1, clears in low-level mode, or treats a write as a set. A dedicated case lands a clear write in exactly the cycle an edge is detected. A design that let the clear win would lose that event and read 0.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_BOTH = 2'b11
  } det_mode_e;

  localparam logic SEL_TYPE = 1'b0;
  localparam logic SEL_STAT = 1'b1;
endpackage

// File: rtl/extirq_rst_sync.sv
module extirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_line.sv
module extirq_line
  import extirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  det_mode_e mode_i,
  input  logic      pin_i,
  input  logic      clr_req_i,
  output logic      status_o
);
  logic s1_q, s2_q, prev_q, stat_q;
  logic s1_d, s2_d, prev_d, stat_d;
  logic rise, fall, edge_hit, edge_mode, stat_en;

  always_comb begin
    s1_d      = pin_i;
    s2_d      = s1_q;
    prev_d    = s2_q;
    rise      = s2_q & ~prev_q;
    fall      = ~s2_q & prev_q;
    edge_mode = (mode_i != DET_LOW);
    unique case (mode_i)
      DET_FALL: edge_hit = fall;
      DET_RISE: edge_hit = rise;
      DET_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
    if (!edge_mode) stat_d = ~s2_q;
    else            stat_d = edge_hit | (stat_q & ~clr_req_i);
    stat_en = (stat_d != stat_q);
  end

  // synchroniser resets to the idle-high level so release causes no event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && edge_hit) |=> stat_q); // R5
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && edge_hit && clr_req_i) |=> stat_q); // R11
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && stat_q && clr_req_i && !edge_hit) |=> !stat_q); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && stat_q && !clr_req_i) |=> stat_q); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !stat_q && !edge_hit) |=> !stat_q); // R9
  AST_LEVEL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && clr_req_i && $stable(s2_q) && stat_q == !s2_q) |=> $stable(stat_q)); // R10
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NLINES = 4,
  localparam int DW = 2 * NLINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_pin_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [NLINES-1:0] irq_o
);
  logic              rst_sync_n;
  logic [DW-1:0]     type_q, type_d;
  logic              type_we;
  logic [NLINES-1:0] status;
  logic [NLINES-1:0] clr_req;

  extirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    type_we = bus_wr_i && (bus_sel_i == SEL_TYPE);
    type_d  = bus_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  type_q <= '0;
    else if (type_we) type_q <= type_d;
  end

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      assign clr_req[g] = bus_wr_i && (bus_sel_i == SEL_STAT) && !bus_wdata_i[g];
      extirq_line u_line (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .mode_i    (det_mode_e'(type_q[2*g+1:2*g])),
        .pin_i     (irq_pin_i[g]),
        .clr_req_i (clr_req[g]),
        .status_o  (status[g])
      );
    end
  endgenerate

  always_comb begin
    if (bus_sel_i == SEL_TYPE) bus_rdata_o = type_q;
    else                       bus_rdata_o = {{(DW-NLINES){1'b0}}, status};
  end

  assign irq_o = status;

  AST_TYPE_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    type_we |=> (type_q == $past(bus_wdata_i))); // R2
  AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !type_we |=> $stable(type_q)); // R2
endmodule

// File: tb/extirq_ctrl_test.sv
module extirq_ctrl_test;
  localparam int N = 4;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pins;
  logic          sel;
  logic          wr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [N-1:0] expv;

  always #5 clk = ~clk;

  extirq_ctrl #(.NLINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pins), .bus_sel_i(sel),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic bus_write(input logic s, input logic [DW-1:0] d);
    @(negedge clk);
    sel = s; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pin_set(input int i, input logic v);
    @(negedge clk);
    pins[i] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_status(input logic [N-1:0] e, input string req);
    logic [DW-1:0] got;
    sel = 1'b1;
    #1;
    got = rdata;
    checks++;
    if (got !== {{(DW-N){1'b0}}, e}) begin
      errors++;
      $display("FAIL %s status got %h expected %h", req, got, e);
    end
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL R3 irq got %h expected %h", irq, e);
    end
  endtask

  task automatic chk_type(input logic [DW-1:0] e, input string req);
    sel = 1'b0;
    #1;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s type got %h expected %h", req, rdata, e);
    end
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = '1; sel = 1'b0; wr = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_type('0, "R1");
    chk_status('0, "R1");

    // R2 readback of an arbitrary pattern
    bus_write(1'b0, 8'hE4);
    chk_type(8'hE4, "R2");

    for (int m = 0; m < 4; m++) begin
      bus_write(1'b0, {N{m[1:0]}});
      chk_type({N{m[1:0]}}, "R2");
      bus_write(1'b1, '0);
      expv = '0;
      chk_status(expv, (m == 0) ? "R4" : "R8");
      for (int i = 0; i < N; i++) begin
        pin_set(i, 1'b0);
        if (m == 0 || m == 1 || m == 3) expv[i] = 1'b1;
        chk_status(expv, mode_req(m));
        chk_status(expv, "R12");
        bus_write(1'b1, '1);
        chk_status(expv, (m == 0) ? "R10" : "R9");
        bus_write(1'b1, ~({{(DW-1){1'b0}}, 1'b1} << i));
        if (m != 0) expv[i] = 1'b0;
        chk_status(expv, (m == 0) ? "R10" : "R8");
        bus_write(1'b1, ~({{(DW-1){1'b0}}, 1'b1} << i));
        chk_status(expv, (m == 0) ? "R10" : "R9");
        pin_set(i, 1'b1);
        if (m == 0) expv[i] = 1'b0;
        else if (m >= 2) expv[i] = 1'b1;
        chk_status(expv, mode_req(m));
        repeat (5) @(negedge clk);
        chk_status(expv, (m == 0) ? "R4" : "R9");
        bus_write(1'b1, '0);
        if (m != 0) expv = '0;
        chk_status(expv, (m == 0) ? "R10" : "R8");
      end
    end

    // R11: clear write lands in the cycle the edge is detected
    bus_write(1'b0, {N{2'b11}});
    pin_set(2, 1'b0);
    expv = 4'b0100;
    chk_status(expv, "R7");
    @(negedge clk) pins[2] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; wdata = '0;
    @(negedge clk) wr = 1'b0;
    chk_status(expv, "R11");
    bus_write(1'b1, '0);
    expv = '0;
    chk_status(expv, "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule